// File: doc/BRIEF.md
# VLIW Fetch-Packet Front End

This block supplies instructions to a very-long-instruction-word core. It reads program memory one packet at a time. Each packet is eight 32-bit instructions returned as a single 256-bit word. The packet stream is then handed out to the core one instruction per clock. Fetch runs as four pipelined phases. The first phase picks the next packet address. The second presents it to a synchronous program memory. The third waits one cycle while the memory reads. The fourth captures the returned packet into a small packet queue. Before an instruction leaves, it passes a dispatch register and then a decode register. The decode register drives the outputs.

Execute reports a taken branch with a one-cycle pulse and a target address. The branch has five delay slots, so five more instructions in address order issue after the pulse. The target comes next. Anything fetched beyond the delay slots is thrown away. Fetch restarts at the packet that holds the target, and issue begins at the target's word within that packet. The interrupt-enable output stays low for as long as a branch is in flight.

Top module: `vliw_fetch_frontend`

## Requirements
- R1: While reset is asserted, `iss_valid` and `imem_req` are 0 and `int_enable` is 1. After release, the first memory request uses address `RESET_ADDR` and the first issued instruction has that address.
- R2: The packet read at byte address P holds the instruction for address P+4*i in bits [32*i+31 : 32*i], for i = 0..7. Every issued `iss_instr` equals the word of memory at `iss_pc`. Memory data is sampled exactly one cycle after the request cycle.
- R3: Every request address is a multiple of 32. In straight-line code, consecutive requests step by 32 bytes, starting at `RESET_ADDR`.
- R4: With no branch, instructions issue in rising address order, 4 bytes apart. Once the first instruction has issued after reset, `iss_valid` is 1 on every cycle.
- R5: When `br_taken` is sampled high and no branch is pending, the next five issued instructions continue in address order and the sixth is the target. Bits [1:0] of `br_target` are ignored.
- R6: Words of the target packet that lie below the target are not issued. After the target, issue continues in address order and crosses into the following packets.
- R7: `int_enable` is 0 in any cycle with `br_taken` high. It stays 0 from the accepted pulse until the cycle in which the target issues, and it is 1 again in that cycle.
- R8: A `br_taken` pulse that arrives while a branch is pending is ignored: neither its target nor its timing affects the issue stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_taken | input | 1 | One-cycle pulse from execute: branch taken |
| br_target | input | 32 | Byte address of the branch target |
| imem_req | output | 1 | Program memory read strobe |
| imem_addr | output | 32 | Packet-aligned read address |
| imem_rdata | input | 256 | Packet returned one cycle after the request |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_pc | output | 32 | Address of the issued instruction |
| iss_instr | output | 32 | Issued instruction word |
| int_enable | output | 1 | Low while a branch is in flight |

## Verification
The bench uses the default parameters: eight-word packets, a four-packet queue, five delay slots and reset address 0. A memory model with a one-cycle read answers every request from an address hash, so the content of each issued word is predictable. Branch targets are drawn across a 64 KiB window and placed at every word offset, including the last word of a packet. This exercises partial-packet restarts and the step into the next packet. A second reset followed by an immediate branch covers a redirect that is taken before the queue holds anything.

// File: rtl/fe_pkg.sv
`timescale 1ns/1ps
package fe_pkg;
  localparam int unsigned FE_INSTR_W = 32;
  localparam int unsigned FE_ADDR_W  = 32;

  typedef enum logic [1:0] {
    BR_IDLE,
    BR_SLOTS,
    BR_REFETCH,
    BR_DRAIN
  } br_state_t;

  // clear the byte offset inside a packet
  function automatic logic [FE_ADDR_W-1:0] pkt_align(input logic [FE_ADDR_W-1:0] a,
                                                     input int unsigned pkt_bytes);
    logic [FE_ADDR_W-1:0] m;
    m = pkt_bytes - 1;
    return a & ~m;
  endfunction

  function automatic logic [FE_ADDR_W-1:0] word_align(input logic [FE_ADDR_W-1:0] a);
    return {a[FE_ADDR_W-1:2], 2'b00};
  endfunction

  // delay slots still to be taken from the queue when a branch is accepted
  function automatic int unsigned slots_from_queue(input int unsigned slots,
                                                   input logic in_dispatch,
                                                   input logic popping);
    return slots - int'(in_dispatch) - int'(popping);
  endfunction
endpackage

// File: rtl/fe_fetch.sv
`timescale 1ns/1ps
module fe_fetch
  import fe_pkg::*;
#(
  parameter int unsigned PKT_WORDS = 8,
  parameter int unsigned QDEPTH = 4,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                flush,
  input  logic [FE_ADDR_W-1:0]                redir_addr,
  input  logic [$clog2(QDEPTH+1)-1:0]         q_cnt,
  output logic                                imem_req,
  output logic [FE_ADDR_W-1:0]                imem_addr,
  input  logic [PKT_WORDS*FE_INSTR_W-1:0]     imem_rdata,
  output logic                                pkt_push,
  output logic [PKT_WORDS*FE_INSTR_W-1:0]     pkt_data,
  output logic [FE_ADDR_W-1:0]                pkt_addr
);
  localparam int unsigned PKT_BYTES = PKT_WORDS * 4;
  localparam int unsigned BOFF_W    = $clog2(PKT_BYTES);
  localparam int unsigned CNT_W     = $clog2(QDEPTH+1);

  logic [FE_ADDR_W-1:0] gen_pc;     // address-generate phase
  logic                 wait_v;     // wait phase holds a live request
  logic [FE_ADDR_W-1:0] wait_addr;
  logic [CNT_W:0]       occupancy;
  logic                 launch;

  assign occupancy = {1'b0, q_cnt} + (CNT_W+1)'(imem_req) + (CNT_W+1)'(wait_v);
  assign launch    = !flush && (occupancy < (CNT_W+1)'(QDEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_pc    <= pkt_align(RESET_ADDR, PKT_BYTES);
      imem_req  <= 1'b0;
      imem_addr <= '0;
      wait_v    <= 1'b0;
      wait_addr <= '0;
    end else if (flush) begin
      gen_pc   <= pkt_align(redir_addr, PKT_BYTES);
      imem_req <= 1'b0;
      wait_v   <= 1'b0;
    end else begin
      wait_v    <= imem_req;
      wait_addr <= imem_addr;
      imem_req  <= launch;
      if (launch) begin
        imem_addr <= gen_pc;
        gen_pc    <= gen_pc + FE_ADDR_W'(PKT_BYTES);
      end
    end
  end

  // read-opcode phase: packet written into the queue at the next edge
  assign pkt_push = wait_v && !flush;
  assign pkt_data = imem_rdata;
  assign pkt_addr = wait_addr;

  assert_req_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> (imem_addr[BOFF_W-1:0] == '0));

  assert_req_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && $past(imem_req)) |-> (imem_addr == $past(imem_addr) + FE_ADDR_W'(PKT_BYTES)));
endmodule

// File: rtl/fe_pktq.sv
`timescale 1ns/1ps
module fe_pktq
  import fe_pkg::*;
#(
  parameter int unsigned PKT_WORDS = 8,
  parameter int unsigned QDEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [$clog2(PKT_WORDS)-1:0]     flush_off,
  input  logic                             push,
  input  logic [PKT_WORDS*FE_INSTR_W-1:0]  push_data,
  input  logic [FE_ADDR_W-1:0]             push_addr,
  input  logic                             pop,
  output logic                             nonempty,
  output logic [$clog2(QDEPTH+1)-1:0]      q_cnt,
  output logic [FE_INSTR_W-1:0]            head_instr,
  output logic [FE_ADDR_W-1:0]             head_pc
);
  localparam int unsigned PKT_W  = PKT_WORDS * FE_INSTR_W;
  localparam int unsigned OFF_W  = $clog2(PKT_WORDS);
  localparam int unsigned PTR_W  = $clog2(QDEPTH);
  localparam int unsigned CNT_W  = $clog2(QDEPTH+1);

  logic [PKT_W-1:0]     slot_data [QDEPTH];
  logic [FE_ADDR_W-1:0] slot_addr [QDEPTH];
  logic [PTR_W-1:0]     wr_ptr, rd_ptr;
  logic [OFF_W-1:0]     word_idx;
  logic                 last_word, dequeue;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QDEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty   = (q_cnt != '0);
  assign last_word  = (word_idx == OFF_W'(PKT_WORDS-1));
  assign dequeue    = pop && last_word;
  assign head_instr = slot_data[rd_ptr][int'(word_idx)*FE_INSTR_W +: FE_INSTR_W];
  assign head_pc    = slot_addr[rd_ptr] + (FE_ADDR_W'(word_idx) << 2);

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      slot_data[wr_ptr] <= push_data;
      slot_addr[wr_ptr] <= push_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      q_cnt    <= '0;
      word_idx <= '0;
    end else if (flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      q_cnt    <= '0;
      word_idx <= flush_off;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop) word_idx <= last_word ? '0 : word_idx + 1'b1;
      if (dequeue) rd_ptr <= ptr_next(rd_ptr);
      q_cnt <= q_cnt + CNT_W'(push) - CNT_W'(dequeue);
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (q_cnt < CNT_W'(QDEPTH) || dequeue));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/fe_issue.sv
`timescale 1ns/1ps
module fe_issue
  import fe_pkg::*;
#(
  parameter int unsigned PKT_WORDS = 8,
  parameter int unsigned DELAY_SLOTS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          br_taken,
  input  logic [FE_ADDR_W-1:0]          br_target,
  input  logic                          q_nonempty,
  input  logic [FE_INSTR_W-1:0]         q_instr,
  input  logic [FE_ADDR_W-1:0]          q_pc,
  output logic                          pop,
  output logic                          flush,
  output logic [FE_ADDR_W-1:0]          redir_addr,
  output logic [$clog2(PKT_WORDS)-1:0]  redir_off,
  output logic                          iss_valid,
  output logic [FE_ADDR_W-1:0]          iss_pc,
  output logic [FE_INSTR_W-1:0]         iss_instr,
  output logic                          int_enable
);
  localparam int unsigned OFF_W  = $clog2(PKT_WORDS);
  localparam int unsigned SLOT_W = $clog2(DELAY_SLOTS+1);

  br_state_t             state;
  logic [SLOT_W-1:0]     slots_left;
  logic [FE_ADDR_W-1:0]  tgt_q;
  logic                  dp_v, dp_tgt, dc_tgt;
  logic [FE_ADDR_W-1:0]  dp_pc;
  logic [FE_INSTR_W-1:0] dp_instr;
  logic                  accept;

  assign accept     = br_taken && (state == BR_IDLE);
  assign flush      = (state == BR_SLOTS) && (slots_left == '0);
  assign pop        = q_nonempty && !flush;
  assign redir_addr = tgt_q;
  assign redir_off  = tgt_q[OFF_W+1:2];
  assign int_enable = (state == BR_IDLE) && !br_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= BR_IDLE;
      slots_left <= '0;
      tgt_q      <= '0;
    end else begin
      unique case (state)
        BR_IDLE: if (accept) begin
          state      <= BR_SLOTS;
          tgt_q      <= word_align(br_target);
          slots_left <= SLOT_W'(slots_from_queue(DELAY_SLOTS, dp_v, pop));
        end
        BR_SLOTS: begin
          if (slots_left == '0) state <= BR_REFETCH;
          else if (pop) slots_left <= slots_left - 1'b1;
        end
        BR_REFETCH: if (pop) state <= BR_DRAIN;
        BR_DRAIN: if (dp_v && dp_tgt) state <= BR_IDLE;
        default: state <= BR_IDLE;
      endcase
    end
  end

  // dispatch then decode registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_v      <= 1'b0;
      dp_tgt    <= 1'b0;
      dp_pc     <= '0;
      dp_instr  <= '0;
      iss_valid <= 1'b0;
      dc_tgt    <= 1'b0;
      iss_pc    <= '0;
      iss_instr <= '0;
    end else begin
      dp_v      <= pop;
      dp_tgt    <= pop && (state == BR_REFETCH);
      dp_pc     <= q_pc;
      dp_instr  <= q_instr;
      iss_valid <= dp_v;
      dc_tgt    <= dp_v && dp_tgt;
      iss_pc    <= dp_pc;
      iss_instr <= dp_instr;
    end
  end

  assert_seq_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid) && !dc_tgt) |-> (iss_pc == $past(iss_pc) + 32'd4));

  assert_target_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dc_tgt |-> (iss_valid && iss_pc == tgt_q));

  assert_mask_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !int_enable);
endmodule

// File: rtl/vliw_fetch_frontend.sv
`timescale 1ns/1ps
module vliw_fetch_frontend
  import fe_pkg::*;
#(
  parameter int unsigned PKT_WORDS = 8,
  parameter int unsigned QDEPTH = 4,
  parameter int unsigned DELAY_SLOTS = 5,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            br_taken,
  input  logic [31:0]                     br_target,
  output logic                            imem_req,
  output logic [31:0]                     imem_addr,
  input  logic [PKT_WORDS*32-1:0]         imem_rdata,
  output logic                            iss_valid,
  output logic [31:0]                     iss_pc,
  output logic [31:0]                     iss_instr,
  output logic                            int_enable
);
  localparam int unsigned PKT_W = PKT_WORDS * FE_INSTR_W;
  localparam int unsigned OFF_W = $clog2(PKT_WORDS);
  localparam int unsigned CNT_W = $clog2(QDEPTH+1);

  logic                 flush, pop, pkt_push, q_nonempty;
  logic [FE_ADDR_W-1:0] redir_addr, pkt_addr, q_pc;
  logic [OFF_W-1:0]     redir_off;
  logic [CNT_W-1:0]     q_cnt;
  logic [PKT_W-1:0]     pkt_data;
  logic [FE_INSTR_W-1:0] q_instr;

  fe_fetch #(.PKT_WORDS(PKT_WORDS), .QDEPTH(QDEPTH), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .redir_addr(redir_addr), .q_cnt(q_cnt),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .pkt_push(pkt_push), .pkt_data(pkt_data), .pkt_addr(pkt_addr)
  );

  fe_pktq #(.PKT_WORDS(PKT_WORDS), .QDEPTH(QDEPTH)) u_pktq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_off(redir_off),
    .push(pkt_push), .push_data(pkt_data), .push_addr(pkt_addr), .pop(pop),
    .nonempty(q_nonempty), .q_cnt(q_cnt), .head_instr(q_instr), .head_pc(q_pc)
  );

  fe_issue #(.PKT_WORDS(PKT_WORDS), .DELAY_SLOTS(DELAY_SLOTS)) u_issue (
    .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_target(br_target),
    .q_nonempty(q_nonempty), .q_instr(q_instr), .q_pc(q_pc), .pop(pop), .flush(flush),
    .redir_addr(redir_addr), .redir_off(redir_off), .iss_valid(iss_valid),
    .iss_pc(iss_pc), .iss_instr(iss_instr), .int_enable(int_enable)
  );
endmodule

// File: tb/test_vliw_fetch_frontend.sv
`timescale 1ns/1ps
module test_vliw_fetch_frontend;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         br_taken = 1'b0;
  logic [31:0]  br_target = '0;
  logic         imem_req;
  logic [31:0]  imem_addr;
  logic [255:0] imem_rdata = '0;
  logic         iss_valid;
  logic [31:0]  iss_pc, iss_instr;
  logic         int_enable;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vliw_fetch_frontend i_vliw_fetch_frontend (
    .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_target(br_target),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_instr(iss_instr), .int_enable(int_enable)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F ^ (a >> 7);
  endfunction

  function automatic logic [255:0] packet_at(input logic [31:0] a);
    logic [255:0] p;
    for (int i = 0; i < 8; i++) p[i*32 +: 32] = word_at(a + 32'(4*i));
    return p;
  endfunction

  // one-cycle synchronous program memory
  always @(posedge clk) if (imem_req) imem_rdata <= packet_at(imem_addr);

  // reference model state
  logic [31:0] exp_pc = 32'h0;
  logic [31:0] tgt = 32'h0;
  logic [31:0] last_tgt_seen = 32'h0;
  logic [31:0] next_req = 32'h0;
  int  br_cnt = 0;
  bit  pend = 0;
  bit  after_tgt = 0;
  bit  seen_first = 0;
  bit  cont_mode = 0;
  bit  req_seq = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (iss_valid) begin
      if (pend && br_cnt == 0) begin
        check(iss_pc == exp_pc, "R5 target", iss_pc, exp_pc);
        last_tgt_seen = iss_pc;
        pend = 0;
        after_tgt = 1;
      end else begin
        check(iss_pc == exp_pc, after_tgt ? "R6 after target" : "R4 order", iss_pc, exp_pc);
        after_tgt = 0;
      end
      check(iss_instr == word_at(iss_pc), "R2 content", iss_instr, word_at(iss_pc));
      seen_first = 1;
      if (br_cnt > 0) begin
        br_cnt--;
        exp_pc = (br_cnt == 0) ? tgt : iss_pc + 32'd4;
      end else begin
        exp_pc = iss_pc + 32'd4;
      end
    end else if (cont_mode && seen_first) begin
      check(1'b0, "R4 bubble", 32'(iss_valid), 32'd1);
    end
    check(int_enable == !pend, "R7 mask", 32'(int_enable), 32'(!pend));
    if (imem_req) begin
      check(imem_addr[4:0] == 5'd0, "R3 align", imem_addr, imem_addr & ~32'h1F);
      if (req_seq) begin
        check(imem_addr == next_req, "R3 step", imem_addr, next_req);
        next_req = imem_addr + 32'd32;
      end
    end
  endtask

  task automatic do_branch(input logic [31:0] t);
    br_taken  = 1'b1;
    br_target = t;
    pend   = 1;
    br_cnt = 5;
    tgt    = {t[31:2], 2'b00};
    #1;
    check(int_enable == 1'b0, "R7 same cycle", 32'(int_enable), 32'd0);
    step();
    br_taken = 1'b0;
  endtask

  task automatic ignored_branch(input logic [31:0] t);
    br_taken  = 1'b1;
    br_target = t;
    step();
    br_taken = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (pend && guard < 300) begin
      step();
      guard++;
    end
    if (pend) check(1'b0, "R5 target never issued", 32'd0, tgt);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    br_taken = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(iss_valid == 1'b0, "R1 reset valid", 32'(iss_valid), 32'd0);
      check(int_enable == 1'b1, "R1 reset int_enable", 32'(int_enable), 32'd1);
      check(imem_req == 1'b0, "R1 reset req", 32'(imem_req), 32'd0);
    end
    exp_pc = 32'h0; br_cnt = 0; pend = 0; after_tgt = 0; seen_first = 0;
    next_req = 32'h0;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1 + R3 + R4: straight-line run from reset address 0
    apply_reset();
    req_seq = 1;
    cont_mode = 1;
    repeat (120) step();
    check(seen_first, "R1 first issue", 32'(seen_first), 32'd1);
    cont_mode = 0;
    req_seq = 0;

    // R5: target at packet offset 0
    do_branch(32'h0000_1000);
    wait_idle();
    // R6: target at the last word of a packet, then into the next packet
    do_branch(32'h0000_201C);
    wait_idle();
    repeat (4) step();
    // R5: low address bits ignored
    do_branch(32'h0000_3006);
    wait_idle();
    // R8: second pulse while pending is dropped
    do_branch(32'h0000_4000);
    ignored_branch(32'h0000_5000);
    step();
    ignored_branch(32'h0000_5100);
    wait_idle();
    check(last_tgt_seen == 32'h0000_4000, "R8 ignored pulse", last_tgt_seen, 32'h0000_4000);
    // back-to-back: branch in the same cycle the target is seen
    do_branch(32'h0000_4444);
    wait_idle();

    // R5: branch on the first cycle after reset, empty queue
    apply_reset();
    do_branch(32'h0000_6010);
    wait_idle();

    // random branches with random gaps
    for (int n = 0; n < 40; n++) begin
      int gap = $urandom % 12;
      repeat (gap) step();
      do_branch($urandom & 32'h0000_FFFF);
      wait_idle();
    end

    // R4: steady issue resumes after a redirect
    repeat (20) step();
    cont_mode = 1;
    repeat (60) step();
    cont_mode = 0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule